// File: doc/BRIEF.md
# Address-Decoded Output Port Bank

This block sits on the I/O side of a 20-bit-address processor bus. It provides a bank of byte-wide output latches. Each latch drives eight output lines and keeps its value until software writes that latch again. The block watches the address, the memory-or-I/O select, the low data byte and the active-low write strobe. From these it decides whether the current bus cycle is an I/O write aimed at the bank.

A write qualifies when the select marks an I/O cycle and address bit 15 is set. Address bits 3..1 pick one of the eight latches, so the latches occupy the even addresses 8000h through 800Eh. Bit 0 takes no part in decoding. The address, select and data are sampled while the strobe is low. The new byte is committed when the strobe is seen rising. Memory cycles, reads and addresses with bit 15 clear leave every latch untouched.

Top module: `ioport_bank`

## Requirements
- R1: After a clock edge with `rst` high, every output byte reads 00h, and a strobe that was low before reset causes no write once reset is released.
- R2: An I/O write (`mem_io` = 0, address bit 15 = 1) stores the data byte into the port numbered by address bits 3..1. The stored value appears on the clock edge that samples `wr_n` high right after a sample of it low. Example: 8000h selects port 0 and 8002h selects port 1.
- R3: A port keeps its value until a qualifying write to that same port. Writes to the other ports leave it unchanged.
- R4: A cycle with `mem_io` = 1 changes no port.
- R5: A cycle whose address bit 15 is 0 changes no port.
- R6: Address bit 0 is ignored. An odd address writes the even port just below it, for example 8003h writes port 1.
- R7: Address bits 19..16 and 14..4 do not affect which port is written.
- R8: The stored byte and port are the ones present at the last clock sample with `wr_n` low. Nothing is written while the strobe stays low, and bus changes after the strobe rises are not taken.
- R9: Writes separated by a single high sample of `wr_n` all take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 20 | Bus address |
| mem_io | input | 1 | 1 = memory cycle, 0 = I/O cycle |
| wr_n | input | 1 | Active-low write strobe |
| wdata | input | 8 | Low data byte of the bus |
| port_q | output | 8x8 | Latched output ports, index = port number |

## Verification
A rising write strobe and a reset can land on the same clock edge. The bench provokes this by raising `wr_n` on the cycle in which `rst` is asserted, after a full low phase that targets port 3. It judges the result by seeing all ports at 00h right after reset. It then checks that they stay at 00h on the following edge, which shows the strobe history was cleared and not committed late.

// File: rtl/ioport_pkg.sv
`timescale 1ns/1ps
package ioport_pkg;

    localparam int unsigned BUS_ADDR_W = 20;
    localparam int unsigned BYTE_W     = 8;
    localparam int unsigned PORT_CNT   = 8;
    localparam int unsigned SEL_W      = $clog2(PORT_CNT);
    localparam int unsigned SEL_LSB    = 1;
    localparam int unsigned EN_BIT     = 15;

    typedef logic [SEL_W-1:0]  port_idx_t;
    typedef logic [BYTE_W-1:0] byte_t;

    // Bus fields that matter for decoding, sampled during the strobe-low phase
    typedef struct packed {
        logic      io_cyc;   // 1 when the cycle targets I/O space
        logic      dec_en;   // decoder enable address bit
        port_idx_t sel;      // port number from the address
        byte_t     data;
    } bus_cap_t;

    function automatic bus_cap_t make_cap(input logic      mem_sel,
                                          input logic      en_bit,
                                          input port_idx_t sel,
                                          input byte_t     data);
        bus_cap_t c;
        c.io_cyc = ~mem_sel;
        c.dec_en = en_bit;
        c.sel    = sel;
        c.data   = data;
        return c;
    endfunction

    function automatic logic cap_hits(input bus_cap_t c);
        return c.io_cyc & c.dec_en;
    endfunction

endpackage

// File: rtl/ioport_strobe.sv
`timescale 1ns/1ps
module ioport_strobe
    import ioport_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     wr_n,
    input  bus_cap_t bus_now,
    output logic     commit,
    output bus_cap_t held
);

    logic wr_n_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_n_q <= 1'b1;
            held   <= '0;
        end else begin
            wr_n_q <= wr_n;
            if (!wr_n) begin
                held <= bus_now;
            end
        end
    end

    // Strobe seen high now after a low sample: the write phase just ended
    assign commit = wr_n & ~wr_n_q;

    // R9
    commit_single_chk: assert property (@(posedge clk) disable iff (rst)
        commit |=> !commit);

endmodule

// File: rtl/ioport_decode.sv
`timescale 1ns/1ps
module ioport_decode
    import ioport_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                commit,
    input  bus_cap_t            held,
    output logic [PORT_CNT-1:0] port_en
);

    logic hit;

    assign hit = commit & cap_hits(held);

    for (genvar i = 0; i < PORT_CNT; i++) begin : g_sel
        assign port_en[i] = hit & (held.sel == SEL_W'(i));
    end

    // R2
    en_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(port_en));

    // R8
    en_needs_commit_chk: assert property (@(posedge clk) disable iff (rst)
        !commit |-> (port_en == '0));

endmodule

// File: rtl/ioport_latch.sv
`timescale 1ns/1ps
module ioport_latch #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (en) begin
            q <= d;
        end
    end

    // R2
    load_chk: assert property (@(posedge clk) disable iff (rst)
        en |=> (q == $past(d)));

    // R3
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(q));

endmodule

// File: rtl/ioport_bank.sv
`timescale 1ns/1ps
module ioport_bank
    import ioport_pkg::*;
(
    input  logic                              clk,
    input  logic                              rst,
    input  logic [BUS_ADDR_W-1:0]             addr,
    input  logic                              mem_io,
    input  logic                              wr_n,
    input  logic [BYTE_W-1:0]                 wdata,
    output logic [PORT_CNT-1:0][BYTE_W-1:0]   port_q
);

    bus_cap_t            bus_now;
    bus_cap_t            held;
    logic                commit;
    logic [PORT_CNT-1:0] port_en;
    logic                addr_unused;

    // Address bits outside the enable bit and the select field play no part
    assign addr_unused = ^{addr[BUS_ADDR_W-1:EN_BIT+1],
                           addr[EN_BIT-1:SEL_LSB+SEL_W],
                           addr[SEL_LSB-1:0]};

    assign bus_now = make_cap(mem_io, addr[EN_BIT],
                              addr[SEL_LSB +: SEL_W], wdata);

    ioport_strobe u_strobe (
        .clk     (clk),
        .rst     (rst),
        .wr_n    (wr_n),
        .bus_now (bus_now),
        .commit  (commit),
        .held    (held)
    );

    ioport_decode u_decode (
        .clk     (clk),
        .rst     (rst),
        .commit  (commit),
        .held    (held),
        .port_en (port_en)
    );

    for (genvar p = 0; p < PORT_CNT; p++) begin : g_port
        ioport_latch #(.W(BYTE_W)) u_latch (
            .clk (clk),
            .rst (rst),
            .en  (port_en[p]),
            .d   (held.data),
            .q   (port_q[p])
        );
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (port_q == '0));

    // R4
    mem_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (commit && !held.io_cyc) |=> $stable(port_q));

    // R5
    enable_bit_chk: assert property (@(posedge clk) disable iff (rst)
        (commit && !held.dec_en) |=> $stable(port_q));

endmodule

// File: tb/test_ioport_bank.sv
`timescale 1ns/1ps
module test_ioport_bank;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [19:0] addr = '0;
    logic        mem_io = 1'b1;
    logic        wr_n = 1'b1;
    logic [7:0]  wdata = '0;
    logic [7:0][7:0] port_q;

    logic [7:0] model [8];
    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    ioport_bank i_ioport_bank (
        .clk    (clk),
        .rst    (rst),
        .addr   (addr),
        .mem_io (mem_io),
        .wr_n   (wr_n),
        .wdata  (wdata),
        .port_q (port_q)
    );

    // {addr, mem_io, data, writes, port}
    localparam int NV = 14;
    localparam logic [32:0] VEC [NV] = '{
        {20'h08000, 1'b0, 8'h11, 1'b1, 3'd0},  // R2
        {20'h08002, 1'b0, 8'h22, 1'b1, 3'd1},  // R2
        {20'h08004, 1'b0, 8'h33, 1'b1, 3'd2},  // R2
        {20'h08006, 1'b0, 8'h44, 1'b1, 3'd3},  // R2
        {20'h08008, 1'b0, 8'h55, 1'b1, 3'd4},  // R2
        {20'h0800A, 1'b0, 8'h66, 1'b1, 3'd5},  // R2
        {20'h0800C, 1'b0, 8'h77, 1'b1, 3'd6},  // R2
        {20'h0800E, 1'b0, 8'h88, 1'b1, 3'd7},  // R2
        {20'h08002, 1'b1, 8'hAA, 1'b0, 3'd0},  // R4 memory cycle
        {20'h00002, 1'b0, 8'hBB, 1'b0, 3'd0},  // R5 bit 15 clear
        {20'h08003, 1'b0, 8'hCC, 1'b1, 3'd1},  // R6 odd alias
        {20'hFFFF8, 1'b0, 8'hDD, 1'b1, 3'd4},  // R7 other bits set
        {20'h07FFE, 1'b0, 8'hEE, 1'b0, 3'd0},  // R5 only bit 15 clear
        {20'h0800F, 1'b0, 8'h5A, 1'b1, 3'd7}   // R6 odd alias top
    };

    task automatic check_all(input string req);
        for (int p = 0; p < 8; p++) begin
            checks++;
            if (port_q[p] !== model[p]) begin
                errors++;
                $display("FAIL %s port %0d actual %02h expected %02h",
                         req, p, port_q[p], model[p]);
            end
        end
    endtask

    // One bus write: one low sample of the strobe, then high; ends at a negedge
    task automatic bus_write(input logic [19:0] a, input logic m, input logic [7:0] d);
        addr = a; mem_io = m; wdata = d; wr_n = 1'b0;
        @(negedge clk);
        wr_n = 1'b1;
        addr = 20'h0800E; mem_io = 1'b0; wdata = 8'hFF;  // R8 later values must not be taken
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int p = 0; p < 8; p++) model[p] = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_all("R1 reset");

        // Vector walk, back-to-back writes (R9), others hold (R3)
        for (int v = 0; v < NV; v++) begin
            bus_write(VEC[v][32:13], VEC[v][12], VEC[v][11:4]);
            if (VEC[v][3]) model[VEC[v][2:0]] = VEC[v][11:4];
            check_all($sformatf("R2/R3/R9 vector %0d", v));
        end

        // R8: strobe held low, bus changing; last low sample wins
        addr = 20'h08004; mem_io = 1'b0; wdata = 8'h01; wr_n = 1'b0;
        @(negedge clk);
        wdata = 8'h02; addr = 20'h0800A;
        @(negedge clk);
        check_all("R8 no write while low");
        @(negedge clk);
        wr_n = 1'b1; wdata = 8'h03; addr = 20'h08000;
        @(negedge clk);
        model[5] = 8'h02;
        check_all("R8 last low sample");

        // R9: two writes one high sample apart
        bus_write(20'h08004, 1'b0, 8'hA4);
        bus_write(20'h08008, 1'b0, 8'hB8);
        model[2] = 8'hA4; model[4] = 8'hB8;
        check_all("R9 back to back");

        // R1: strobe rise coincides with reset
        addr = 20'h08006; mem_io = 1'b0; wdata = 8'h3C; wr_n = 1'b0;
        @(negedge clk);
        wr_n = 1'b1; rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        for (int p = 0; p < 8; p++) model[p] = 8'h00;
        check_all("R1 reset with strobe rise");
        @(negedge clk);
        check_all("R1 no late commit");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule